// File: doc/BRIEF.md
# Programming Frame Receiver and Validator

This block sits behind the byte receiver of a flash-programming link. It takes one byte per handshake on a valid/ready input and sorts the stream into two frame kinds. A command frame carries a command code plus parameters. A data frame carries a payload and says whether more payload frames follow. The block checks each frame's header, length, checksum and footer, and produces a one-byte status code for whatever builds the response.

The payload of a frame is held in an internal buffer until the footer has been checked. It is forwarded on the output stream only when the frame is accepted. A command frame is forwarded as its command byte followed by its parameters. A data frame is forwarded as its data bytes. A last-frame flag rides on the final data byte when the frame closed the transfer. While a payload is being forwarded, the input is held off.

Top module: `prog_frame_rx`

## Requirements
- R1: A synchronous active-high reset leaves `in_ready` high and `out_valid` and `stat_valid` low.
- R2: While idle, any byte other than 0x01 (command header) or 0x02 (data header) is dropped, with no status and no output.
- R3: An accepted command frame (01, LEN, CMD, params, SUM, 03) gives status 0x06, then streams CMD followed by the params with `out_kind`=0. LEN counts CMD plus params. The checksum is 0x00 minus LEN minus every byte between LEN and SUM, modulo 256.
- R4: A frame with a valid footer whose checksum byte differs from the computed value gives status 0x07 and streams nothing.
- R5: A command frame with a correct footer and checksum, whose code is not one of 00, 13, 20, 22, 32, 40, 9A, A0, B0, C0, C5, gives status 0x04 and streams nothing.
- R6: A command frame with a correct footer and checksum and a supported code gives status 0x05 when LEN is wrong for that code. Codes 00, 20, C0 and C5 need LEN 1. Codes 9A and A0 need LEN 3. Codes 13, 22, 32, 40 and B0 need LEN 7. A command LEN of 0 means no command byte follows; that frame is header, LEN, SUM, footer, and it gives 0x05 when footer and checksum are correct.
- R7: An accepted data frame (02, LEN, data, SUM, footer) gives status 0x06 and streams the data with `out_kind`=1. `out_last` is high only on the final byte, and only when the footer was 0x03. Footer 0x17 means more frames follow.
- R8: A data frame with LEN 0x00 carries 256 data bytes.
- R9: A footer other than 0x03 (or other than 0x03/0x17 for data frames) gives status 0x15 and takes priority over every other error.
- R10: A reset in the middle of a frame discards the partial frame. The next header starts a fresh frame.
- R11: `in_ready` is low on every cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Command, parameter or data byte |
| out_kind | output | 1 | 0 command frame content, 1 data frame content |
| out_last | output | 1 | Final byte of the last data frame |
| stat_valid | output | 1 | One-cycle strobe of a frame verdict |
| stat_code | output | 8 | Verdict code: 04, 05, 06, 07 or 15 |

## Verification
The bench builds the block with the default buffer depth of 256 bytes. At that depth the largest data frame, with length byte 0x00, fits whole. This brings the 256-byte wrap of the length field and the full replay of a buffer-sized payload within reach. Random frames mix valid and corrupted checksums, both footers, and supported and unknown codes with right and wrong lengths. These exercise every path through the verdict priority at this depth.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int LEN_W = 9;
  localparam logic [7:0] HDR_CMD = 8'h01;
  localparam logic [7:0] HDR_DAT = 8'h02;
  localparam logic [7:0] FT_END  = 8'h03;
  localparam logic [7:0] FT_MORE = 8'h17;
  localparam logic [7:0] ST_UNK  = 8'h04;
  localparam logic [7:0] ST_PARM = 8'h05;
  localparam logic [7:0] ST_ACK  = 8'h06;
  localparam logic [7:0] ST_SUM  = 8'h07;
  localparam logic [7:0] ST_FOOT = 8'h15;

  typedef enum logic [2:0] {P_IDLE, P_LEN, P_BODY, P_SUM, P_FOOT, P_PLAY} pstate_t;

  // Required length byte per command code; 0 marks an unknown code.
  function automatic logic [3:0] cmd_need(input logic [7:0] c);
    case (c)
      8'h00, 8'h20, 8'hC0, 8'hC5:        cmd_need = 4'd1;
      8'h9A, 8'hA0:                      cmd_need = 4'd3;
      8'h13, 8'h22, 8'h32, 8'h40, 8'hB0: cmd_need = 4'd7;
      default:                           cmd_need = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pfr_store.sv
module pfr_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfr_parser.sv
module pfr_parser
  import pfr_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             stat_valid,
  output logic [7:0]       stat_code,
  output logic             play_go,
  output logic [LEN_W-1:0] play_cnt,
  output logic             play_kind,
  output logic             play_last,
  input  logic             play_done
);
  pstate_t          state;
  logic             is_data;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       sum;
  logic [7:0]       first;
  logic             sum_ok;
  logic             beat;
  logic             foot_ok;
  logic [7:0]       verdict;

  assign in_ready  = (state != P_PLAY);
  assign beat      = in_valid && in_ready;
  assign wr_en     = beat && (state == P_BODY) && (cnt < LEN_W'(DEPTH));
  assign wr_addr   = cnt[AW-1:0];
  assign wr_data   = in_data;
  assign play_cnt  = len;
  assign play_kind = is_data;

  // Verdict priority: footer, checksum, then frame-kind checks.
  always_comb begin
    foot_ok = (in_data == FT_END) || (is_data && in_data == FT_MORE);
    if (!foot_ok)                               verdict = ST_FOOT;
    else if (!sum_ok)                           verdict = ST_SUM;
    else if (is_data)                           verdict = (len > LEN_W'(DEPTH)) ? ST_PARM : ST_ACK;
    else if (len == '0)                         verdict = ST_PARM;
    else if (cmd_need(first) == 4'd0)           verdict = ST_UNK;
    else if (len != LEN_W'(cmd_need(first)))    verdict = ST_PARM;
    else                                        verdict = ST_ACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= P_IDLE;
      is_data    <= 1'b0;
      len        <= '0;
      cnt        <= '0;
      sum        <= 8'h00;
      first      <= 8'h00;
      sum_ok     <= 1'b0;
      stat_valid <= 1'b0;
      stat_code  <= 8'h00;
      play_go    <= 1'b0;
      play_last  <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      play_go    <= 1'b0;
      case (state)
        P_IDLE: if (beat) begin
          if (in_data == HDR_CMD) begin
            is_data <= 1'b0;
            state   <= P_LEN;
          end else if (in_data == HDR_DAT) begin
            is_data <= 1'b1;
            state   <= P_LEN;
          end
        end
        P_LEN: if (beat) begin
          sum <= 8'h00 - in_data;
          cnt <= '0;
          if (in_data == 8'h00) begin
            if (is_data) begin
              len   <= LEN_W'(256);
              state <= P_BODY;
            end else begin
              len   <= '0;
              state <= P_SUM;
            end
          end else begin
            len   <= {1'b0, in_data};
            state <= P_BODY;
          end
        end
        P_BODY: if (beat) begin
          sum <= sum - in_data;
          if (cnt == '0) first <= in_data;
          cnt <= cnt + 1'b1;
          if (cnt == len - 1'b1) state <= P_SUM;
        end
        P_SUM: if (beat) begin
          sum_ok <= (in_data == sum);
          state  <= P_FOOT;
        end
        P_FOOT: if (beat) begin
          stat_valid <= 1'b1;
          stat_code  <= verdict;
          if (verdict == ST_ACK) begin
            play_go   <= 1'b1;
            play_last <= is_data && (in_data == FT_END);
            state     <= P_PLAY;
          end else begin
            state <= P_IDLE;
          end
        end
        P_PLAY: if (play_done) state <= P_IDLE;
        default: state <= P_IDLE;
      endcase
    end
  end

  // R9
  stat_legal_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_code == ST_ACK || stat_code == ST_SUM || stat_code == ST_UNK ||
                    stat_code == ST_PARM || stat_code == ST_FOOT));

  // R2
  stat_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(in_valid && in_ready));
endmodule

// File: rtl/pfr_play.sv
module pfr_play
  import pfr_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] cnt,
  input  logic             kind,
  input  logic             last,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             out_valid,
  output logic             out_kind,
  output logic             out_last,
  output logic             done
);
  logic             busy;
  logic [LEN_W-1:0] ptr;
  logic             fin;

  assign fin     = (ptr == cnt - 1'b1);
  assign rd_en   = busy;
  assign rd_addr = ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_kind  <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= busy;
      out_kind  <= kind;
      out_last  <= busy && fin && last;
      done      <= busy && fin;
      if (go) begin
        busy <= 1'b1;
        ptr  <= '0;
      end else if (busy) begin
        ptr <= ptr + 1'b1;
        if (fin) busy <= 1'b0;
      end
    end
  end

  // R7
  last_on_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_kind));
endmodule

// File: rtl/prog_frame_rx.sv
module prog_frame_rx
  import pfr_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_kind,
  output logic       out_last,
  output logic       stat_valid,
  output logic [7:0] stat_code
);
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic             play_go;
  logic [LEN_W-1:0] play_cnt;
  logic             play_kind;
  logic             play_last;
  logic             play_done;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;

  pfr_parser #(.DEPTH(DEPTH)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_valid(stat_valid), .stat_code(stat_code),
    .play_go(play_go), .play_cnt(play_cnt), .play_kind(play_kind),
    .play_last(play_last), .play_done(play_done)
  );

  pfr_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(out_data)
  );

  pfr_play #(.DEPTH(DEPTH)) u_play (
    .clk(clk), .rst(rst), .go(play_go), .cnt(play_cnt), .kind(play_kind), .last(play_last),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid), .out_kind(out_kind),
    .out_last(out_last), .done(play_done)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !stat_valid && in_ready));

  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R3
  stream_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(stat_valid, 2) && $past(stat_code, 2) == ST_ACK));

  // R4
  no_stream_on_bad_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_code == ST_SUM) |=> !out_valid);
endmodule

// File: tb/prog_frame_rx_test.sv
module prog_frame_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_kind, out_last, stat_valid;
  logic [7:0] out_data, stat_code;

  int checks = 0;
  int errors = 0;
  int overlap = 0;
  logic [7:0]  pbuf [0:299];
  logic [7:0]  sq [$];
  logic [9:0]  oq [$];

  always #2 clk = ~clk;

  prog_frame_rx uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_kind(out_kind), .out_last(out_last),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (stat_valid) sq.push_back(stat_code);
      if (out_valid) oq.push_back({out_last, out_kind, out_data});
      if (out_valid && in_ready) overlap++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int need_len(input logic [7:0] c);
    case (c)
      8'h00, 8'h20, 8'hC0, 8'hC5:        return 1;
      8'h9A, 8'hA0:                      return 3;
      8'h13, 8'h22, 8'h32, 8'h40, 8'hB0: return 7;
      default:                           return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input bit isd, input logic [7:0] lenb,
                                          input logic [7:0] delta, input logic [7:0] ft,
                                          input logic [7:0] code);
    if (!(ft == 8'h03 || (isd && ft == 8'h17))) return 8'h15;
    if (delta != 8'h00) return 8'h07;
    if (isd) return 8'h06;
    if (lenb == 8'h00) return 8'h05;
    if (need_len(code) == 0) return 8'h04;
    if (need_len(code) != int'(lenb)) return 8'h05;
    return 8'h06;
  endfunction

  function automatic logic [7:0] pick_cmd(input int i);
    case (i % 11)
      0: return 8'h00;  1: return 8'h9A;  2: return 8'h20;  3: return 8'h22;
      4: return 8'h40;  5: return 8'h13;  6: return 8'h32;  7: return 8'hC0;
      8: return 8'hC5;  9: return 8'hB0;  default: return 8'hA0;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_frame(input bit isd, input logic [7:0] lenb, input logic [7:0] delta,
                          input logic [7:0] ft, input string req);
    int pc;
    int bad;
    logic [7:0] s;
    logic [7:0] e;
    pc = isd ? ((lenb == 8'h00) ? 256 : int'(lenb)) : int'(lenb);
    s = 8'h00 - lenb;
    for (int i = 0; i < pc; i++) s = s - pbuf[i];
    sq.delete();
    oq.delete();
    send_byte(isd ? 8'h02 : 8'h01);
    send_byte(lenb);
    for (int i = 0; i < pc; i++) send_byte(pbuf[i]);
    send_byte(s + delta);
    send_byte(ft);
    repeat (300) @(negedge clk);
    e = exp_stat(isd, lenb, delta, ft, pbuf[0]);
    check(sq.size() == 1 && sq[0] == e, req, (sq.size() > 0) ? int'(sq[0]) : -1, int'(e));
    if (e == 8'h06) begin
      bad = 0;
      for (int i = 0; i < oq.size() && i < pc; i++) begin
        if (oq[i] != {isd && (ft == 8'h03) && (i == pc - 1), isd, pbuf[i]}) bad++;
      end
      check(oq.size() == pc && bad == 0, {req, " stream"}, oq.size() * 1000 + bad, pc * 1000);
    end else begin
      check(oq.size() == 0, {req, " no stream"}, oq.size(), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    int n;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready && !out_valid && !stat_valid, "R1", {in_ready, out_valid, stat_valid}, 3'b100);

    // R2 idle bytes dropped
    sq.delete(); oq.delete();
    send_byte(8'h55); send_byte(8'h03); send_byte(8'h17); send_byte(8'hFF);
    repeat (20) @(negedge clk);
    check(sq.size() == 0 && oq.size() == 0 && in_ready, "R2", sq.size() + oq.size(), 0);

    // R3 accepted commands
    pbuf[0] = 8'h00;
    do_frame(1'b0, 8'd1, 8'h00, 8'h03, "R3 cmd00");
    pbuf[0] = 8'h22;
    for (int i = 1; i < 7; i++) pbuf[i] = 8'(i * 37);
    do_frame(1'b0, 8'd7, 8'h00, 8'h03, "R3 cmd22");
    pbuf[0] = 8'h9A; pbuf[1] = 8'h12; pbuf[2] = 8'hFE;
    do_frame(1'b0, 8'd3, 8'h00, 8'h03, "R3 cmd9A");

    // R4 checksum errors
    pbuf[0] = 8'hC0;
    do_frame(1'b0, 8'd1, 8'h01, 8'h03, "R4 cmd");
    for (int i = 0; i < 4; i++) pbuf[i] = 8'hA5;
    do_frame(1'b1, 8'd4, 8'h80, 8'h17, "R4 data");

    // R5 unknown command
    pbuf[0] = 8'h55;
    do_frame(1'b0, 8'd1, 8'h00, 8'h03, "R5");

    // R6 length mismatch and zero length
    pbuf[0] = 8'h22; pbuf[1] = 8'h01; pbuf[2] = 8'h02;
    do_frame(1'b0, 8'd3, 8'h00, 8'h03, "R6 short");
    do_frame(1'b0, 8'd0, 8'h00, 8'h03, "R6 len0");

    // R7 data frames, both footers
    for (int i = 0; i < 5; i++) pbuf[i] = 8'(8'h10 + i);
    do_frame(1'b1, 8'd5, 8'h00, 8'h03, "R7 end");
    do_frame(1'b1, 8'd5, 8'h00, 8'h17, "R7 more");

    // R8 length byte zero is 256
    for (int i = 0; i < 256; i++) pbuf[i] = 8'(i ^ 8'h5C);
    do_frame(1'b1, 8'd0, 8'h00, 8'h03, "R8");

    // R9 footer errors outrank others
    pbuf[0] = 8'h20;
    do_frame(1'b0, 8'd1, 8'h00, 8'h17, "R9 cmd");
    do_frame(1'b1, 8'd1, 8'h00, 8'h44, "R9 data");
    do_frame(1'b0, 8'd1, 8'h33, 8'h02, "R9 with bad sum");

    // R10 reset mid-frame
    sq.delete(); oq.delete();
    send_byte(8'h01); send_byte(8'h07); send_byte(8'h22);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    pbuf[0] = 8'hC5;
    do_frame(1'b0, 8'd1, 8'h00, 8'h03, "R10");

    // random mix
    for (int k = 0; k < 60; k++) begin
      r = $urandom % 4;
      if (r == 0) begin
        pbuf[0] = pick_cmd($urandom);
        for (int i = 1; i < 8; i++) pbuf[i] = 8'($urandom);
        do_frame(1'b0, 8'(need_len(pbuf[0])), 8'h00, 8'h03, "R3 rand");
      end else if (r == 1) begin
        n = 1 + $urandom % 40;
        for (int i = 0; i < n; i++) pbuf[i] = 8'($urandom);
        do_frame(1'b1, 8'(n), 8'h00, ($urandom % 2) ? 8'h03 : 8'h17, "R7 rand");
      end else if (r == 2) begin
        n = 1 + $urandom % 8;
        for (int i = 0; i < n; i++) pbuf[i] = 8'($urandom);
        do_frame(1'b0, 8'(n), 8'h00, 8'h03, "R6 rand");
      end else begin
        n = 1 + $urandom % 20;
        for (int i = 0; i < n; i++) pbuf[i] = 8'($urandom);
        do_frame(1'b1, 8'(n), 8'(1 + $urandom % 255), ($urandom % 3 == 0) ? 8'h5A : 8'h03,
                 "R4 rand");
      end
    end

    // R11 input held off during output
    check(overlap == 0, "R11", overlap, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule